// File: doc/BRIEF.md
# Command-Word Decoder with Low-Frequency Carrier Divider

This block sits on the programmable-logic side of a reader front end. A host microcontroller sends it 16-bit command words over a four-wire serial link in SPI mode 0. The block synchronises the serial lines to its own reference clock and splits each complete word into a 4-bit opcode and a 12-bit operand. It then writes the operand into one of two registers. One register holds the operating configuration, which includes a 3-bit major-mode field. The other holds the carrier divisor.

From the divisor the block derives the antenna carrier. The reference clock is divided by divisor+1, and the output is high for the first half of each period. With a 12 MHz reference, divisor 95 gives 125 kHz and divisor 88 gives about 134.8 kHz. The host may rewrite the divisor at any moment, for example while sweeping the antenna across a frequency range. The carrier moves to the new value at its next period boundary, so the waveform never contains a shortened pulse.

Top module: `lf_cmd_carrier`

## Requirements
- R1: A word is taken MSB first. The opcode is received bits [15:12] and the operand is bits [11:0].
- R2: Opcode 1 loads the 12-bit operand into the configuration register, which appears on `cfg_word`.
- R3: Opcode 2 loads the 12-bit operand into the divisor register, which appears on `divisor`.
- R4: Any opcode other than 1 or 2 leaves both registers unchanged.
- R5: A word is acted on only when chip select rises after exactly 16 clock rising edges. Any other bit count discards the transfer.
- R6: The data line is sampled on rising serial-clock edges while chip select is low (clock idles low).
- R7: Reset is synchronous and active high. It sets the configuration to 0 and the divisor to 95.
- R8: The carrier period is divisor+1 reference cycles. Within each period the output is high for floor((divisor+1)/2) cycles and low for the rest.
- R9: A new divisor takes effect only at the end of the current carrier period. Every high and every low phase therefore has the length for either the old divisor or the new one.
- R10: `major_mode` is `cfg_word[7:5]`. The carrier is enabled only when `major_mode` is 0 (reader). When it is disabled, `carrier_clk` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (12 MHz in the target use) |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from host, idles low |
| spi_cs_n | input | 1 | Chip select from host, active low |
| spi_mosi | input | 1 | Serial data from host |
| cfg_word | output | 12 | Configuration register contents |
| major_mode | output | 3 | Major-mode field of the configuration |
| divisor | output | 12 | Divisor register contents |
| carrier_en | output | 1 | High while the reader mode is selected |
| carrier_clk | output | 1 | Divided carrier clock, gated by carrier_en |

## Verification
The assertions check, on every cycle, the invariants that hold between neighbouring cycles. The configuration and divisor registers change only on a matching opcode strobe. The word strobe lasts a single cycle. The shift register moves only on a sampling edge. The active divisor is held steady inside a period, and the gated carrier is never high while disabled. Other properties span whole transfers and whole carrier periods: MSB-first ordering, rejection of bit counts other than 16, and the exact high and low phase lengths across a sweep of divisors. Only the bench scenarios can show these.

// File: rtl/lf_cmd_pkg.sv
package lf_cmd_pkg;
    localparam int WORD_W = 16;
    localparam int OP_W   = 4;
    localparam int ARG_W  = WORD_W - OP_W;
    localparam int MM_LSB = 5;
    localparam int MM_W   = 3;

    localparam logic [OP_W-1:0] OP_SET_CFG = OP_W'(1);
    localparam logic [OP_W-1:0] OP_SET_DIV = OP_W'(2);
    localparam logic [MM_W-1:0] MODE_LF_READER = MM_W'(0);
    localparam logic [MM_W-1:0] MODE_LF_SIM    = MM_W'(1);

    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [ARG_W-1:0] arg;
    } cmd_word_t;

    // cycles the carrier spends high for a given divisor
    function automatic logic [ARG_W:0] high_len(input logic [ARG_W-1:0] d);
        logic [ARG_W:0] p;
        p = {1'b0, d} + (ARG_W+1)'(1);
        return p >> 1;
    endfunction
endpackage

// File: rtl/spi_word_rx.sv
module spi_word_rx
    import lf_cmd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      sclk,
    input  logic      cs_n,
    input  logic      mosi,
    output logic      word_valid,
    output cmd_word_t word
);
    localparam int CNT_W   = $clog2(WORD_W + 2);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

    logic [SYNC_STAGES-1:0] sy_sclk, sy_cs, sy_mosi;
    logic sclk_q, cs_q, mosi_q, sclk_d, cs_d;
    logic sclk_rise, cs_rise, cs_fall;
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  bitcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sy_sclk <= '0;
            sy_cs   <= '1;
            sy_mosi <= '0;
            sclk_d  <= 1'b0;
            cs_d    <= 1'b1;
        end else begin
            sy_sclk <= {sy_sclk[SYNC_STAGES-2:0], sclk};
            sy_cs   <= {sy_cs[SYNC_STAGES-2:0], cs_n};
            sy_mosi <= {sy_mosi[SYNC_STAGES-2:0], mosi};
            sclk_d  <= sclk_q;
            cs_d    <= cs_q;
        end
    end

    assign sclk_q    = sy_sclk[SYNC_STAGES-1];
    assign cs_q      = sy_cs[SYNC_STAGES-1];
    assign mosi_q    = sy_mosi[SYNC_STAGES-1];
    assign sclk_rise = sclk_q & ~sclk_d;
    assign cs_rise   = cs_q & ~cs_d;
    assign cs_fall   = ~cs_q & cs_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg      <= '0;
            bitcnt     <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (cs_fall) begin
                bitcnt <= '0;
            end else if (!cs_q && sclk_rise) begin
                shreg <= {shreg[WORD_W-2:0], mosi_q};
                if (bitcnt != CNT_SAT)
                    bitcnt <= bitcnt + CNT_W'(1);
            end
            if (cs_rise && bitcnt == CNT_FULL)
                word_valid <= 1'b1;
        end
    end

    assign word = cmd_word_t'(shreg);

    // R5: a completed transfer produces one strobe only
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> !word_valid);
    // R6: shifting happens only on a sampling edge inside a transfer
    a_r6_shift_on_edge: assert property (@(posedge clk) disable iff (rst)
        !(sclk_rise && !cs_q) |=> $stable(shreg));
endmodule

// File: rtl/cmd_regs.sv
module cmd_regs
    import lf_cmd_pkg::*;
#(
    parameter logic [ARG_W-1:0] DIV_RESET = ARG_W'(95)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  cmd_word_t        word,
    output logic [ARG_W-1:0] cfg,
    output logic [ARG_W-1:0] div
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
            div <= DIV_RESET;
        end else if (wr) begin
            case (word.op)
                OP_SET_CFG: cfg <= word.arg;
                OP_SET_DIV: div <= word.arg;
                default: ;
            endcase
        end
    end

    // R2/R4: configuration moves only on an opcode-1 strobe
    a_r2_cfg_guard: assert property (@(posedge clk) disable iff (rst)
        !(wr && word.op == OP_SET_CFG) |=> $stable(cfg));
    // R3/R4: divisor moves only on an opcode-2 strobe
    a_r4_div_guard: assert property (@(posedge clk) disable iff (rst)
        !(wr && word.op == OP_SET_DIV) |=> $stable(div));
endmodule

// File: rtl/carrier_gen.sv
module carrier_gen
    import lf_cmd_pkg::*;
#(
    parameter logic [ARG_W-1:0] DIV_RESET = ARG_W'(95)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [ARG_W-1:0] div,
    output logic             carrier
);
    logic [ARG_W-1:0] cnt;
    logic [ARG_W-1:0] div_act;
    logic             last;

    assign last = (cnt == div_act);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            div_act <= DIV_RESET;
        end else if (last) begin
            cnt     <= '0;
            div_act <= div;
        end else begin
            cnt <= cnt + ARG_W'(1);
        end
    end

    assign carrier = ({1'b0, cnt} < high_len(div_act));

    // R9: the active divisor is frozen inside a period
    a_r9_no_runt: assert property (@(posedge clk) disable iff (rst)
        !last |=> $stable(div_act));
    // R8: phase counter never runs past the period end
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= div_act);
endmodule

// File: rtl/lf_cmd_carrier.sv
module lf_cmd_carrier
    import lf_cmd_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [ARG_W-1:0]  DIV_RESET   = ARG_W'(95)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             spi_sclk,
    input  logic             spi_cs_n,
    input  logic             spi_mosi,
    output logic [ARG_W-1:0] cfg_word,
    output logic [MM_W-1:0]  major_mode,
    output logic [ARG_W-1:0] divisor,
    output logic             carrier_en,
    output logic             carrier_clk
);
    logic      wr;
    cmd_word_t word;
    logic      carrier_raw;

    spi_word_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst(rst), .sclk(spi_sclk), .cs_n(spi_cs_n), .mosi(spi_mosi),
        .word_valid(wr), .word(word)
    );

    cmd_regs #(.DIV_RESET(DIV_RESET)) u_regs (
        .clk(clk), .rst(rst), .wr(wr), .word(word), .cfg(cfg_word), .div(divisor)
    );

    carrier_gen #(.DIV_RESET(DIV_RESET)) u_car (
        .clk(clk), .rst(rst), .div(divisor), .carrier(carrier_raw)
    );

    assign major_mode  = cfg_word[MM_LSB +: MM_W];
    assign carrier_en  = (major_mode == MODE_LF_READER);
    assign carrier_clk = carrier_en & carrier_raw;

    // R10: no carrier activity outside reader mode
    a_r10_gate: assert property (@(posedge clk) disable iff (rst)
        carrier_clk |-> carrier_en);
endmodule

// File: tb/sim_lf_cmd_carrier.sv
module sim_lf_cmd_carrier;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic [11:0] cfg_word, divisor;
    logic [2:0]  major_mode;
    logic        carrier_en, carrier_clk;
    int checks = 0;
    int fails  = 0;
    localparam int HALF = 6;

    always #2 clk = ~clk;

    lf_cmd_carrier u0 (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
        .cfg_word(cfg_word), .major_mode(major_mode), .divisor(divisor),
        .carrier_en(carrier_en), .carrier_clk(carrier_clk)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // send nbits of value MSB first, mode 0
    task automatic send_bits(input logic [31:0] val, input int nbits);
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int i = nbits - 1; i >= 0; i--) begin
            mosi = val[i];
            wait_clk(HALF);
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
            mosi = (i > 0) ? val[i-1] : 1'b0;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(12);
    endtask

    task automatic send_cmd(input int op, input int arg);
        send_bits({16'd0, op[3:0], arg[11:0]}, 16);
    endtask

    // measure one full high phase and the low phase after it
    task automatic measure(output int h, output int l);
        int guard;
        guard = 0;
        h = 0; l = 0;
        while (carrier_clk !== 1'b0 && guard < 2000) begin wait_clk(1); guard++; end
        while (carrier_clk !== 1'b1 && guard < 2000) begin wait_clk(1); guard++; end
        while (carrier_clk === 1'b1 && guard < 2000) begin h++; wait_clk(1); guard++; end
        while (carrier_clk === 1'b0 && guard < 2000) begin l++; wait_clk(1); guard++; end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        int h, l, d;
        int list[3];
        wait_clk(4);
        rst = 1'b0;
        wait_clk(2);
        // R7 reset state
        chk("R7 cfg", int'(cfg_word), 0);
        chk("R7 div", int'(divisor), 95);
        chk("R10 en at reset", int'(carrier_en), 1);
        measure(h, l);
        chk("R8 high d95", h, 48);
        chk("R8 low d95", l, 48);

        // R8 near-exhaustive sweep of small divisors plus named points
        list = '{88, 255, 19};
        for (int k = 1; k <= 27; k++) begin
            d = (k <= 24) ? k : list[k-25];
            send_cmd(2, d);
            chk("R3 div write", int'(divisor), d);
            wait_clk(2 * 257 + 4);
            measure(h, l);
            chk("R8 high", h, (d + 1) / 2);
            chk("R8 low", l, (d + 1) - (d + 1) / 2);
        end

        // R1 / R2 MSB-first config write, R10 major mode decode
        send_cmd(1, 12'hA5C);
        chk("R1 R2 cfg", int'(cfg_word), 12'hA5C);
        chk("R10 major", int'(major_mode), 2);
        chk("R10 en off", int'(carrier_en), 0);
        // R10 simulator mode: carrier held low
        send_cmd(1, 12'h020);
        chk("R10 major sim", int'(major_mode), 1);
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 300; i++) begin
                if (carrier_clk) seen++;
                wait_clk(1);
            end
            chk("R10 carrier gated", seen, 0);
        end
        send_cmd(1, 12'h003);
        chk("R2 reader opts", int'(cfg_word), 3);
        chk("R10 en back", int'(carrier_en), 1);

        // R4 other opcodes ignored
        send_cmd(2, 40);
        for (int op = 0; op < 16; op++) begin
            if (op != 1 && op != 2) begin
                send_cmd(op, 12'h7E1);
                chk("R4 cfg kept", int'(cfg_word), 3);
                chk("R4 div kept", int'(divisor), 40);
            end
        end

        // R5 wrong bit counts discarded
        send_bits({16'd0, 4'd2, 12'd9} >> 1, 15);
        chk("R5 15 bits", int'(divisor), 40);
        send_bits({15'd0, 1'b1, 4'd2, 12'd9}, 17);
        chk("R5 17 bits", int'(divisor), 40);
        send_bits(32'd0, 0);
        chk("R5 0 bits", int'(divisor), 40);
        // R6 a correct 16-bit write after them lands
        send_cmd(2, 9);
        chk("R6 R3 div", int'(divisor), 9);

        // R9 change while running: every phase is old or new length
        send_cmd(2, 40);
        wait_clk(200);
        measure(h, l);
        send_cmd(2, 7);
        for (int p = 0; p < 6; p++) begin
            measure(h, l);
            chk("R9 high phase", int'(h == 20 || h == 4), 1);
            chk("R9 low phase", int'(l == 21 || l == 4), 1);
        end
        measure(h, l);
        chk("R9 settled high", h, 4);
        chk("R9 settled low", l, 4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule